// File: doc/BRIEF.md
# Sticky Event Flag Register with Selectable Conflict Priority

This block holds a bank of sticky status flags between event sources that run outside the local clock domain and a processor write port. Each event line is brought into the clock domain through a flop chain, and its rising edge is turned into a single-cycle set pulse. That pulse sets the matching flag, and the flag stays set until the processor clears it. The processor clears flags in one of two ways. A write marks bits to clear with ones in a clear word. A separate strobe wipes the whole bank.

A single write can also carry a set word. Software can then fold "clear, then set again" into one bus operation. All sets and clears for a flag are collected in one cycle, and the next state is computed synchronously. A compile-time parameter picks which side wins when both reach the same flag in the same cycle. The interrupt output goes high while any flag is set whose enable bit is also set.

Top module: `evflag_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every bit of `flags` is 0 and `irq` is 0.
- R2: When `evt_in[i]` goes from 0 to 1, `flags[i]` becomes 1 on the (SYNC_STAGES+1)-th rising clock edge after the change, which is the third edge with the default of 2. It is still 0 after the second edge.
- R3: A flag stays at 1 after its event line returns to 0. An event line held at 1 sets its flag only once, so a flag cleared while the line stays high remains 0.
- R4: When `wr_en` is 1, every bit that is 1 in `wr_clr` clears the matching flag, and every bit that is 0 leaves its flag unchanged. When `wr_en` is 0, `wr_clr` has no effect.
- R5: A cycle with `clr_all` at 1 sets every flag to 0 on the next edge, provided no set reaches any flag in that cycle.
- R6: With SET_WINS=1, a flag that receives a set and a clear in the same cycle (from an event edge or from `wr_set`) is 1 after the edge, and `irq` is 1 if its enable bit is set.
- R7: With SET_WINS=0, a flag that receives a set and a clear in the same cycle is 0 after the edge.
- R8: When `wr_en` is 1, every bit that is 1 in `wr_set` sets the matching flag on the next edge.
- R9: `irq` is 1 exactly when some bit i has both `flags[i]` and `irq_en[i]` at 1. A flag whose enable bit is 0 stays set but does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | NUM_FLAGS | Event lines, not synchronous to `clk` |
| wr_en | input | 1 | Write strobe that qualifies `wr_clr` and `wr_set` |
| wr_clr | input | NUM_FLAGS | Clear word: a 1 clears that flag |
| wr_set | input | NUM_FLAGS | Set word: a 1 sets that flag |
| clr_all | input | 1 | Clears every flag |
| irq_en | input | NUM_FLAGS | Interrupt enable per flag |
| flags | output | NUM_FLAGS | Flag state |
| irq | output | 1 | OR of the enabled flags |

## Verification
The hardest case to reach from the ports is an event edge that lands on the same cycle as a processor clear. The set pulse exists for only one cycle, and only after the synchronizer delay. The stimulus raises the event line between edges, counts the edges through the synchronizer and the edge detector, and asserts the clear write in exactly the cycle in which the pulse is live. Two copies of the block, one with set priority and one with clear priority, receive identical stimulus, so the outcome under each policy is compared on the same cycle.

// File: rtl/evflag_pkg.sv
package evflag_pkg;

  // Next value of a single flag, given the merged set and clear requests.
  function automatic logic flag_next(input logic set_req, input logic clr_req,
                                     input logic cur, input bit set_wins);
    logic nxt;
    if (set_wins) nxt = set_req | (cur & ~clr_req);
    else          nxt = ~clr_req & (set_req | cur);
    return nxt;
  endfunction

  // Rising edge of a synchronized level against its delayed copy.
  function automatic logic rise_of(input logic now_lvl, input logic last_lvl);
    return now_lvl & ~last_lvl;
  endfunction

endpackage

// File: rtl/evflag_sync.sv
module evflag_sync #(
  parameter int NUM_FLAGS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_async,
  output logic [NUM_FLAGS-1:0] evt_rise
);
  import evflag_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_FLAGS-1:0] lvl_sync;
  logic [NUM_FLAGS-1:0] lvl_prev;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain       <= '0;
        lvl_prev[i] <= 1'b0;
      end else begin
        chain       <= {chain[SYNC_STAGES-2:0], evt_async[i]};
        lvl_prev[i] <= lvl_sync[i];
      end
    end

    assign lvl_sync[i] = chain[LAST];
    assign evt_rise[i] = rise_of(lvl_sync[i], lvl_prev[i]);

    // R2: an edge produces a pulse of exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rise[i] |=> !evt_rise[i]);
  end

endmodule

// File: rtl/evflag_store.sv
module evflag_store #(
  parameter int NUM_FLAGS = 8,
  parameter bit SET_WINS  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [NUM_FLAGS-1:0] clr_vec,
  output logic [NUM_FLAGS-1:0] q
);
  import evflag_pkg::*;

  logic [NUM_FLAGS-1:0] q_nxt;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
    assign q_nxt[i] = flag_next(set_vec[i], clr_vec[i], q[i], SET_WINS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R3: with no request the flags hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(q));

  // R8: a set with no clear always lands
  a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & ~clr_vec) != '0) |=> ((q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

  // R4: a clear with no set always lands
  a_r4_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((q & $past(clr_vec & ~set_vec)) == '0));

  if (SET_WINS) begin : g_set_pri
    // R6: set wins a same-cycle conflict
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & clr_vec) != '0) |=> ((q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
  end else begin : g_clr_pri
    // R7: clear wins a same-cycle conflict
    a_r7_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & clr_vec) != '0) |=> ((q & $past(set_vec & clr_vec)) == '0));
  end

endmodule

// File: rtl/evflag_irq.sv
module evflag_irq #(
  parameter int NUM_FLAGS = 8
) (
  input  logic [NUM_FLAGS-1:0] q,
  input  logic [NUM_FLAGS-1:0] en,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] armed;

  assign armed = q & en;
  assign irq   = |armed;

endmodule

// File: rtl/evflag_bank.sv
module evflag_bank #(
  parameter int NUM_FLAGS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SET_WINS    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_in,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_clr,
  input  logic [NUM_FLAGS-1:0] wr_set,
  input  logic                 clr_all,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);

  logic [NUM_FLAGS-1:0] evt_rise;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;

  evflag_sync #(.NUM_FLAGS(NUM_FLAGS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_async (evt_in),
    .evt_rise  (evt_rise)
  );

  assign set_vec = evt_rise | (wr_en ? wr_set : '0);
  assign clr_vec = (wr_en ? wr_clr : '0) | {NUM_FLAGS{clr_all}};

  evflag_store #(.NUM_FLAGS(NUM_FLAGS), .SET_WINS(SET_WINS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (flags)
  );

  evflag_irq #(.NUM_FLAGS(NUM_FLAGS)) u_irq (
    .q   (flags),
    .en  (irq_en),
    .irq (irq)
  );

  // R5: the bank-wide clear empties every flag when nothing sets
  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && set_vec == '0) |=> (flags == '0));

  // R9: the interrupt never rises without a flag behind it
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

endmodule

// File: tb/evflag_bank_test.sv
module evflag_bank_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_in = '0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_clr = '0;
  logic [N-1:0] wr_set = '0;
  logic         clr_all = 1'b0;
  logic [N-1:0] irq_en = '0;
  logic [N-1:0] flags, flags_cd;
  logic         irq, irq_cd;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evflag_bank #(.NUM_FLAGS(N), .SET_WINS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .wr_clr(wr_clr),
    .wr_set(wr_set), .clr_all(clr_all), .irq_en(irq_en), .flags(flags), .irq(irq));

  evflag_bank #(.NUM_FLAGS(N), .SET_WINS(1'b0)) uut_cd (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .wr_clr(wr_clr),
    .wr_set(wr_set), .clr_all(clr_all), .irq_en(irq_en), .flags(flags_cd), .irq(irq_cd));

  task automatic check(input string req, input string what, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // advance one edge, return at the following falling edge
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_write(input logic [N-1:0] s, input logic [N-1:0] c);
    wr_en = 1'b1; wr_set = s; wr_clr = c;
    step(1);
    wr_en = 1'b0; wr_set = '0; wr_clr = '0;
  endtask

  task automatic t_reset();
    check("R1", "flags during reset", flags, '0);
    check("R1", "irq during reset", {7'b0, irq}, '0);
    rst_n = 1'b1;
    step(1);
    check("R1", "flags after reset", flags, '0);
    check("R1", "cd flags after reset", flags_cd, '0);
  endtask

  task automatic t_event_latency();
    evt_in[2] = 1'b1;
    step(2);
    check("R2", "flag before sync delay", flags, '0);
    step(1);
    check("R2", "flag after third edge", flags, 8'h04);
    check("R2", "cd flag after third edge", flags_cd, 8'h04);
    evt_in[2] = 1'b0;
    step(4);
    check("R3", "flag sticks after event drops", flags, 8'h04);
  endtask

  task automatic t_bus_ops();
    bus_write(8'hF0, 8'h00);
    check("R8", "software set", flags, 8'hF4);
    bus_write(8'h00, 8'h30);
    check("R4", "w1c clears marked bits only", flags, 8'hC4);
    check("R4", "w1c cd", flags_cd, 8'hC4);
    wr_en = 1'b0; wr_clr = 8'hFF;
    step(1);
    wr_clr = '0;
    check("R4", "clear word ignored without strobe", flags, 8'hC4);
  endtask

  task automatic t_irq();
    irq_en = 8'h00;
    step(1);
    check("R9", "irq with all masked", {7'b0, irq}, 8'h00);
    check("R9", "masked flag stays set", flags, 8'hC4);
    irq_en = 8'h04;
    step(1);
    check("R9", "irq with enabled flag", {7'b0, irq}, 8'h01);
    irq_en = 8'h03;
    step(1);
    check("R9", "irq with enables on clear flags", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_clear_all();
    clr_all = 1'b1;
    step(1);
    clr_all = 1'b0;
    check("R5", "clear all", flags, '0);
    check("R5", "clear all cd", flags_cd, '0);
  endtask

  task automatic t_sw_conflict();
    bus_write(8'h01, 8'h01);
    check("R6", "software set+clear, set wins", flags, 8'h01);
    check("R7", "software set+clear, clear wins", flags_cd, 8'h00);
    clr_all = 1'b1;
    step(1);
    clr_all = 1'b0;
  endtask

  task automatic t_evt_conflict();
    irq_en = 8'h20;
    evt_in[5] = 1'b1;
    step(2);
    // the set pulse is live in this cycle; clear it on the same edge
    bus_write(8'h00, 8'h20);
    check("R6", "event edge vs clear, set wins", flags, 8'h20);
    check("R6", "irq after set wins", {7'b0, irq}, 8'h01);
    check("R7", "event edge vs clear, clear wins", flags_cd, 8'h00);
    check("R7", "irq after clear wins", {7'b0, irq_cd}, 8'h00);
    step(3);
    check("R3", "held line does not set again", flags_cd, 8'h00);
    bus_write(8'h00, 8'h20);
    step(3);
    check("R3", "held line stays cleared", flags, 8'h00);
    evt_in[5] = 1'b0;
    step(3);
  endtask

  initial begin
    step(2);
    t_reset();
    t_event_latency();
    t_bus_ops();
    t_irq();
    t_clear_all();
    t_sw_conflict();
    t_evt_conflict();
    done = 1'b1;
    summary();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

endmodule